// File: doc/BRIEF.md
# Byte-Serial Hash Command Front-End

This block is the bus-side controller of a hash accelerator that only ever processes 32-byte messages. A host talks to it over a narrow command bus: a 2-bit opcode strobe picks one of three commands, message bytes arrive one per accepted cycle on a separate byte strobe, and digest bytes leave one per cycle with an output-valid strobe. A readout ends with a valid/ready acknowledge handshake.

Internally the controller gathers the 32 message bytes into a shift register and pads them with fixed logic, which is cheap because the length never varies. It presents the resulting 512-bit block to a separate compression engine, starts that engine with a one-cycle pulse, and on the engine's done pulse captures the 256-bit digest. The engine is not part of this block.

Commands are decoded only when the controller is idle, so a host cannot disturb a load, a running hash, a readout or a pending acknowledge. Any number of load, hash and readout sequences may follow each other without a reset.

Top module: `sha_cmd_frontend`

## Requirements
- R1: Opcode encodings are load = 2'b01, hash = 2'b11, readout = 2'b10. Opcode 2'b00 has no effect. An opcode is taken only when cmd_valid is high and the controller is idle.
- R2: After a load command, the next 32 cycles with in_valid high each supply one byte, and cycles with in_valid low are skipped. The first byte becomes eng_block[511:504] and the 32nd byte becomes eng_block[263:256].
- R3: The padding is fixed. eng_block[255:224] = 32'h80000000, eng_block[223:64] is zero, and eng_block[63:0] = 64'd256.
- R4: A hash command raises eng_start for exactly one cycle, in the cycle after the command. eng_block stays stable until eng_done. eng_done then captures eng_digest and returns the controller to idle.
- R5: A readout command gives 32 consecutive cycles of out_valid, starting two cycles after the command. The bytes come most significant first, so byte k is digest[255-8k -: 8] of the captured digest.
- R6: In the cycle after the last digest byte, out_valid falls and ack_valid rises. ack_valid holds until ack_ready is sampled high, falls in the next cycle, and the controller is then idle.
- R7: Opcodes that arrive during a load, while waiting for the engine, during a readout or while ack_valid is high are ignored. They cause no new eng_start, no new readout and no change to the message.
- R8: Back-to-back sequences without a reset work. Each load replaces the whole message, and each hash replaces the captured digest.
- R9: After reset, out_valid, ack_valid and eng_start are low, the message is all zero (eng_block equals the padding of a zero message), and a readout returns 32 zero bytes.
- R10: in_valid outside a load, and eng_done outside the wait for the engine, have no effect on the message or on the captured digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Opcode strobe |
| cmd_op | input | 2 | Opcode |
| in_valid | input | 1 | Message byte strobe |
| in_byte | input | 8 | Message byte |
| out_valid | output | 1 | Digest byte strobe |
| out_byte | output | 8 | Digest byte |
| ack_valid | output | 1 | Readout finished, waiting for acknowledge |
| ack_ready | input | 1 | Host acknowledge |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_block | output | 512 | Padded message block |
| eng_done | input | 1 | Engine finished |
| eng_digest | input | 256 | Engine result |

## Verification
The bench places byte gaps inside a load and feeds stray bytes and a null opcode before it. A collector that counted idle cycles, or that accepted bytes outside a load, would then shift the message and produce a wrong block and digest. It injects hash and readout opcodes during the engine wait and during a readout: a controller that decoded them would emit a second start pulse or a readout longer than 32 bytes. It also fires a stray done pulse while idle and reads the digest again, which exposes an unguarded capture. Random messages run back-to-back and include a repeated hash without a reload, so a stale message or a stale digest register shows up as a wrong byte.

// File: rtl/sha_fe_pkg.sv
package sha_fe_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_LOAD = 2'b01,
    OP_READ = 2'b10,
    OP_HASH = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_READ,
    ST_ACK
  } st_e;

endpackage

// File: rtl/sha_fe_collect.sv
module sha_fe_collect #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        arm,
  input  logic                        in_valid,
  input  logic [BYTE_W-1:0]           in_byte,
  output logic [N_BYTES*BYTE_W-1:0]   msg,
  output logic                        last_take
);
  localparam int MSG_W = N_BYTES * BYTE_W;
  localparam int CNT_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;

  logic             active;
  logic [CNT_W-1:0] cnt;

  assign last_take = active && in_valid && (cnt == CNT_W'(N_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      msg    <= '0;
    end else if (arm) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && in_valid) begin
      msg <= {msg[MSG_W-BYTE_W-1:0], in_byte};
      cnt <= cnt + 1'b1;
      if (last_take) active <= 1'b0;
    end
  end

  // R2: the byte that completes the message closes the load window
  p_load_closes_r2: assert property (@(posedge clk) disable iff (rst)
    last_take |=> !active);

  // R10: no byte strobe changes the message outside the load window
  p_msg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (!active && !arm) |=> $stable(msg));

endmodule

// File: rtl/sha_fe_pad.sv
module sha_fe_pad #(
  parameter int MSG_W = 256,
  parameter int LEN_W = 64,
  parameter int BLK_W = 512
) (
  input  logic [MSG_W-1:0] msg,
  output logic [BLK_W-1:0] block
);
  localparam int ZERO_W = BLK_W - MSG_W - 1 - LEN_W;

  // fixed length: a single one bit, a zero run, then the bit count
  assign block = {msg, 1'b1, {ZERO_W{1'b0}}, LEN_W'(MSG_W)};

endmodule

// File: rtl/sha_fe_stream.sv
module sha_fe_stream #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cap,
  input  logic [N_BYTES*BYTE_W-1:0]  dig_in,
  input  logic                       go,
  output logic                       out_valid,
  output logic [BYTE_W-1:0]          out_byte,
  output logic                       busy
);
  localparam int DIG_W = N_BYTES * BYTE_W;
  localparam int CNT_W = $clog2(N_BYTES + 1);

  logic [DIG_W-1:0] dig_reg;
  logic [DIG_W-1:0] sh;
  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dig_reg   <= '0;
      sh        <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      if (cap) dig_reg <= dig_in;
      if (go) begin
        sh        <= dig_reg;
        cnt       <= CNT_W'(N_BYTES);
        out_valid <= 1'b0;
      end else if (busy) begin
        out_valid <= 1'b1;
        out_byte  <= sh[DIG_W-1 -: BYTE_W];
        sh        <= sh << BYTE_W;
        cnt       <= cnt - 1'b1;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  // R5: bytes leave back to back while the burst is running
  p_burst_gapless_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && busy) |=> out_valid);

  // R8: the captured digest changes only on a capture
  p_digest_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(dig_reg));

endmodule

// File: rtl/sha_cmd_frontend.sv
module sha_cmd_frontend
  import sha_fe_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MSG_BYTES = 32,
  parameter int DIG_BYTES = 32,
  parameter int LEN_W     = 64,
  parameter int BLK_W     = 512
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cmd_valid,
  input  logic [1:0]                    cmd_op,
  input  logic                          in_valid,
  input  logic [BYTE_W-1:0]             in_byte,
  output logic                          out_valid,
  output logic [BYTE_W-1:0]             out_byte,
  output logic                          ack_valid,
  input  logic                          ack_ready,
  output logic                          eng_start,
  output logic [BLK_W-1:0]              eng_block,
  input  logic                          eng_done,
  input  logic [DIG_BYTES*BYTE_W-1:0]   eng_digest
);
  localparam int MSG_W = MSG_BYTES * BYTE_W;

  st_e              state, state_nx;
  logic             idle_cmd;
  logic             do_load, do_hash, do_read;
  logic             last_take, cap, st_busy;
  logic [MSG_W-1:0] msg;

  assign idle_cmd = (state == ST_IDLE) && cmd_valid;
  assign do_load  = idle_cmd && (op_e'(cmd_op) == OP_LOAD);
  assign do_hash  = idle_cmd && (op_e'(cmd_op) == OP_HASH);
  assign do_read  = idle_cmd && (op_e'(cmd_op) == OP_READ);
  assign cap      = (state == ST_WAIT) && eng_done;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (do_load)      state_nx = ST_LOAD;
        else if (do_hash) state_nx = ST_WAIT;
        else if (do_read) state_nx = ST_READ;
      end
      ST_LOAD: if (last_take) state_nx = ST_IDLE;
      ST_WAIT: if (eng_done)  state_nx = ST_IDLE;
      ST_READ: if (!st_busy)  state_nx = ST_ACK;
      ST_ACK:  if (ack_ready) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      eng_start <= 1'b0;
      ack_valid <= 1'b0;
    end else begin
      state     <= state_nx;
      eng_start <= do_hash;
      ack_valid <= (state_nx == ST_ACK);
    end
  end

  sha_fe_collect #(.BYTE_W(BYTE_W), .N_BYTES(MSG_BYTES)) i_collect (
    .clk       (clk),
    .rst       (rst),
    .arm       (do_load),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .msg       (msg),
    .last_take (last_take)
  );

  sha_fe_pad #(.MSG_W(MSG_W), .LEN_W(LEN_W), .BLK_W(BLK_W)) i_pad (
    .msg   (msg),
    .block (eng_block)
  );

  sha_fe_stream #(.BYTE_W(BYTE_W), .N_BYTES(DIG_BYTES)) i_stream (
    .clk       (clk),
    .rst       (rst),
    .cap       (cap),
    .dig_in    (eng_digest),
    .go        (do_read),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .busy      (st_busy)
  );

  // R4: the start is a single-cycle pulse
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  // R4: the block holds while the engine runs
  p_block_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |=> $stable(eng_block));

  // R7: the wait for the engine is left only through done
  p_wait_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !eng_done) |=> (state == ST_WAIT && !eng_start));

  // R6: the acknowledge holds until it is taken
  p_ack_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !ack_ready) |=> ack_valid);

  // R6: a taken acknowledge drops next cycle
  p_ack_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_ready) |=> !ack_valid);

  // R6: digest bytes and the acknowledge never overlap
  p_out_ack_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && ack_valid));

endmodule

// File: tb/test_sha_cmd_frontend.sv
module test_sha_cmd_frontend;

  localparam int LAT = 7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = 2'b00;
  logic         in_valid = 1'b0;
  logic [7:0]   in_byte = 8'h00;
  logic         out_valid;
  logic [7:0]   out_byte;
  logic         ack_valid;
  logic         ack_ready = 1'b0;
  logic         eng_start;
  logic [511:0] eng_block;
  logic         eng_done = 1'b0;
  logic [255:0] eng_digest = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sha_cmd_frontend i_sha_cmd_frontend (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .in_valid(in_valid), .in_byte(in_byte), .out_valid(out_valid),
    .out_byte(out_byte), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .eng_start(eng_start), .eng_block(eng_block), .eng_done(eng_done),
    .eng_digest(eng_digest)
  );

  function automatic [511:0] pad(input [255:0] m);
    return {m, 32'h80000000, 160'b0, 64'd256};
  endfunction

  function automatic [255:0] mix(input [511:0] b);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = b[511-32*i -: 32] ^ b[255-32*i -: 32];
      w = (w << (i + 1)) | (w >> (31 - i));
      r[255-32*i -: 32] = w ^ (32'h9e3779b9 * (i + 1));
    end
    return r;
  endfunction

  // engine model
  int           eng_cnt = 0;
  logic [511:0] eng_blk = '0;
  logic         spur_req = 1'b0;
  always @(negedge clk) begin
    eng_done = 1'b0;
    if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        eng_done   = 1'b1;
        eng_digest = mix(eng_blk);
      end
    end
    if (spur_req) begin
      eng_done   = 1'b1;
      eng_digest = {8{32'hdeadbeef}};
      spur_req   = 1'b0;
    end
    if (eng_start) begin
      eng_blk = eng_block;
      eng_cnt = LAT;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic load(input logic [255:0] m, input bit gaps);
    int n;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'b01;
    @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'b00;
    n = 0;
    while (n < 32) begin
      if (gaps && ($urandom % 3 == 0)) begin
        in_valid = 1'b0;
        in_byte  = 8'hee;
      end else begin
        in_valid = 1'b1;
        in_byte  = m[255-8*n -: 8];
        n++;
      end
      // R7: an opcode mid-load must not restart the load
      if (n == 5) begin cmd_valid = 1'b1; cmd_op = 2'b01; end
      else begin cmd_valid = 1'b0; cmd_op = 2'b00; end
      @(negedge clk);
    end
    in_valid = 1'b0;
    cmd_valid = 1'b0;
  endtask

  task automatic hash(input logic [255:0] m);
    cmd(2'b11);
    chk(eng_start === 1'b1, "R4 start pulse", 512'(eng_start), 512'd1);
    chk(eng_block === pad(m), "R2/R3 block", eng_block, pad(m));
    @(negedge clk);
    chk(eng_start === 1'b0, "R4 start width", 512'(eng_start), 512'd0);
    cmd_valid = 1'b1; cmd_op = 2'b11;          // R7 hash during wait
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    chk(eng_start === 1'b0, "R7 hash ignored in wait", 512'(eng_start), 512'd0);
    repeat (LAT + 3) @(negedge clk);
    chk(eng_block === pad(m), "R4 block stable", eng_block, pad(m));
  endtask

  task automatic readout(input logic [255:0] d);
    int h;
    cmd(2'b10);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && out_byte === d[255-8*i -: 8], "R5 digest byte",
          {out_valid, out_byte}, {1'b1, d[255-8*i -: 8]});
      if (i == 10) begin cmd_valid = 1'b1; cmd_op = 2'b10; end   // R7
      else begin cmd_valid = 1'b0; cmd_op = 2'b00; end
    end
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && ack_valid === 1'b1, "R6 ack after last byte",
        {out_valid, ack_valid}, 2'b01);
    h = $urandom % 4;
    for (int k = 0; k < h; k++) begin
      cmd_valid = 1'b1; cmd_op = 2'b10;          // R7 opcode while acking
      @(negedge clk);
      chk(ack_valid === 1'b1 && out_valid === 1'b0, "R6 ack held",
          {out_valid, ack_valid}, 2'b01);
    end
    cmd_valid = 1'b0;
    ack_ready = 1'b1;
    @(negedge clk);
    ack_ready = 1'b0;
    chk(ack_valid === 1'b0, "R6 ack released", 512'(ack_valid), 512'd0);
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 no extra readout", 512'(out_valid), 512'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] m, d;
    void'($urandom(32'h5a17c0de));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(out_valid === 1'b0 && ack_valid === 1'b0 && eng_start === 1'b0,
        "R9 reset outputs", {out_valid, ack_valid, eng_start}, 3'b000);
    chk(eng_block === pad('0), "R9/R3 reset block", eng_block, pad('0));
    readout('0);                                  // R9 zero digest

    // R1 null opcode and R10 stray bytes while idle
    cmd(2'b00);
    in_valid = 1'b1; in_byte = 8'h5a;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk(eng_block === pad('0), "R1/R10 ignored input", eng_block, pad('0));

    // directed message: byte k = k+1
    for (int k = 0; k < 32; k++) m[255-8*k -: 8] = 8'(k + 1);
    load(m, 1'b1);
    hash(m);
    d = mix(pad(m));
    readout(d);

    // R10 stray done while idle must not replace the digest
    @(posedge clk); spur_req = 1'b1;
    repeat (3) @(negedge clk);
    readout(d);

    // R8 back to back random runs
    for (int it = 0; it < 6; it++) begin
      m = {$urandom, $urandom, $urandom, $urandom,
           $urandom, $urandom, $urandom, $urandom};
      load(m, it[0]);
      hash(m);
      d = mix(pad(m));
      readout(d);
      if (it == 2) begin
        hash(m);                                  // R8 rehash, same message
        readout(d);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule